// File: doc/BRIEF.md
# Pointer-Driven Nibble Field Selector

This block sits beside a 56-bit register file whose registers are split into 14 four-bit digits. Each digit holds either a BCD digit or a sign, where 0 means positive and 9 means negative. The block keeps a small digit pointer. From a 3-bit field code and the current pointer it produces a 14-bit nibble-enable mask, which the surrounding datapath uses to act on only part of a register. Nibble 13 holds the mantissa sign. Nibbles 12 down to 3 hold the ten mantissa digits. Nibble 2 holds the exponent sign, and nibbles 1 and 0 hold the exponent digits.

Alongside the mask, the block runs the pointer instructions: set the pointer from an immediate, step it up, step it down, and compare it against an immediate for inequality. It also runs a load-constant instruction. This instruction emits a one-nibble write of a BCD digit at the pointer position and then moves the pointer down by one. Repeated load-constant instructions therefore fill a register from the top digit downward. The block does not perform arithmetic on the selected nibbles.

Top module: `nibble_field_sel`

## Requirements
- R1: After reset is released, `ptrOut` is 0, `testFlag` is 0 and `ldWrEn` is 0.
- R2: `fieldMask` depends only on `fieldSel` and the current pointer, with no clock delay. The fixed field codes give these masks: 2 gives 14'h0004 (exponent sign), 3 gives 14'h0003 (exponent), 4 gives 14'h2000 (mantissa sign), 5 gives 14'h1FF8 (mantissa), 6 gives 14'h3FF8 (mantissa and sign) and 7 gives 14'h3FFF (whole word).
- R3: Field code 0 enables only nibble P, so the mask is 1<<P. Field code 1 enables nibbles 0 through P inclusive. For example, P=3 gives 14'h000F.
- R4: When `opValid` is high and `opCode`=1, `ptrOut` equals `immVal` after the next clock edge, provided `immVal` is 13 or less. An `immVal` above 13 leaves the pointer unchanged.
- R5: When `opValid` is high and `opCode`=2, the pointer increments by one at the next edge, and 13 wraps to 0.
- R6: When `opValid` is high and `opCode`=3, the pointer decrements by one at the next edge, and 0 wraps to 13.
- R7: When `opValid` is high and `opCode`=4, `testFlag` is loaded at the next edge with 1 if P differs from `immVal` and with 0 if they are equal. Otherwise `testFlag` holds its value.
- R8: When `opValid` is high, `opCode`=5 and `digitIn` is 9 or less, the following happens in the same cycle. `ldWrEn` is 1, `ldWrMask` is 1<<P, and `ldWrData` carries `digitIn` in bits [4P+3:4P] with zeros elsewhere. At the next edge P decrements, and 0 wraps to 13.
- R9: A load-constant whose `digitIn` is above 9 has no effect: `ldWrEn` stays 0 and the pointer is unchanged.
- R10: With `opValid` low, or with `opCode` 0, 6 or 7, the pointer and `testFlag` keep their values and `ldWrEn` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | Strobe that qualifies `opCode` for this cycle |
| opCode | input | 3 | 0 no-op, 1 load pointer, 2 increment, 3 decrement, 4 not-equal test, 5 load constant |
| fieldSel | input | 3 | Field code that selects the mask |
| immVal | input | 4 | Immediate for load pointer and for the test |
| digitIn | input | 4 | BCD digit for load constant |
| fieldMask | output | 14 | Nibble-enable mask for the selected field |
| ptrOut | output | 4 | Current pointer value |
| testFlag | output | 1 | Result of the last not-equal test |
| ldWrEn | output | 1 | Load-constant write enable |
| ldWrMask | output | 14 | Nibble enable for the load-constant write |
| ldWrData | output | 56 | Write data with the digit placed at nibble P |

## Verification
The bench aims at the pointer wrap points, stepping up from 13 and down from 0 both by plain decrement and by a load-constant run. A design that saturated there, or let the pointer reach 14 or 15, would return the wrong pointer and corrupt every later mask. The word-through-pointer mask is checked at every pointer value, because an off-by-one at either end would drop nibble P or enable nibble P+1. The ignore paths are also exercised: an out-of-range immediate, a non-BCD digit, the unused opcodes and a low strobe. A design that acted on any of these would show a changed pointer, a changed flag or a spurious write. The test flag is checked on both the equal and the unequal case, and it is checked again after other operations to confirm that it holds.

// File: rtl/nibsel_pkg.sv
package nibsel_pkg;

  localparam int NIBBLES     = 14;
  localparam int NIB_W       = 4;
  localparam int PTR_W       = $clog2(NIBBLES);
  localparam int EXP_DIGITS  = 2;
  localparam int WORD_W      = NIBBLES * NIB_W;
  localparam int MAX_DIGIT   = 9;
  localparam int XSIGN_POS   = EXP_DIGITS;
  localparam int MSIGN_POS   = NIBBLES - 1;
  localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(NIBBLES - 1);

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_LDP   = 3'd1,
    OP_INCP  = 3'd2,
    OP_DECP  = 3'd3,
    OP_TSTNE = 3'd4,
    OP_LDC   = 3'd5
  } opCode_e;

  typedef enum logic [2:0] {
    FS_PTR   = 3'd0,
    FS_WTP   = 3'd1,
    FS_XSGN  = 3'd2,
    FS_EXP   = 3'd3,
    FS_MSGN  = 3'd4,
    FS_MANT  = 3'd5,
    FS_MSS   = 3'd6,
    FS_WORD  = 3'd7
  } fieldSel_e;

  typedef struct packed {
    logic             ldP;
    logic             incP;
    logic             decP;
    logic             testNe;
    logic             ldConst;
    logic [PTR_W-1:0] imm;
    logic [NIB_W-1:0] digit;
  } ptrStrobe_t;

endpackage

// File: rtl/nibsel_ctrl.sv
module nibsel_ctrl
  import nibsel_pkg::*;
(
  input  logic             opValid,
  input  logic [2:0]       opCode,
  input  logic [PTR_W-1:0] immVal,
  input  logic [NIB_W-1:0] digitIn,
  output ptrStrobe_t       strb
);

  logic immOk;
  logic digitOk;

  assign immOk   = (immVal <= PTR_MAX);
  assign digitOk = (digitIn <= NIB_W'(MAX_DIGIT));

  always_comb begin
    strb       = '0;
    strb.imm   = immVal;
    strb.digit = digitIn;
    if (opValid) begin
      case (opCode_e'(opCode))
        OP_LDP:   strb.ldP     = immOk;
        OP_INCP:  strb.incP    = 1'b1;
        OP_DECP:  strb.decP    = 1'b1;
        OP_TSTNE: strb.testNe  = 1'b1;
        OP_LDC:   strb.ldConst = digitOk;
        default:  strb         = strb;
      endcase
    end
  end

endmodule

// File: rtl/nibsel_mask.sv
module nibsel_mask
  import nibsel_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [2:0]         fieldSel,
  input  logic [PTR_W-1:0]   ptr,
  output logic [NIBBLES-1:0] maskO
);

  for (genvar gi = 0; gi < NIBBLES; gi++) begin : g_nib
    logic nibSel;
    always_comb begin
      case (fieldSel_e'(fieldSel))
        FS_PTR:  nibSel = (ptr == PTR_W'(gi));
        FS_WTP:  nibSel = (PTR_W'(gi) <= ptr);
        FS_XSGN: nibSel = (gi == XSIGN_POS);
        FS_EXP:  nibSel = (gi < EXP_DIGITS);
        FS_MSGN: nibSel = (gi == MSIGN_POS);
        FS_MANT: nibSel = (gi > XSIGN_POS) && (gi < MSIGN_POS);
        FS_MSS:  nibSel = (gi > XSIGN_POS);
        default: nibSel = 1'b1;
      endcase
    end
    assign maskO[gi] = nibSel;
  end

  // R3: the pointer field enables exactly one nibble
  a_r3_ptr_single: assert property (@(posedge clk) disable iff (!rstN)
    (fieldSel == FS_PTR) |-> ($countones(maskO) == 1));

  // R3: word-through-pointer enables P+1 nibbles, starting at nibble 0
  a_r3_wtp_count: assert property (@(posedge clk) disable iff (!rstN)
    (fieldSel == FS_WTP) |-> (($countones(maskO) == int'(ptr) + 1) && maskO[0]));

  // R2: whole word enables all nibbles
  a_r2_word_full: assert property (@(posedge clk) disable iff (!rstN)
    (fieldSel == FS_WORD) |-> (&maskO));

endmodule

// File: rtl/nibsel_datapath.sv
module nibsel_datapath
  import nibsel_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ptrStrobe_t         strb,
  output logic [PTR_W-1:0]   ptrQ,
  output logic               flagQ,
  output logic               ldWrEn,
  output logic [NIBBLES-1:0] ldWrMask,
  output logic [WORD_W-1:0]  ldWrData
);

  logic [PTR_W-1:0] ptrUp;
  logic [PTR_W-1:0] ptrDn;
  logic             anyStrobe;

  assign ptrUp     = (ptrQ == PTR_MAX) ? '0 : ptrQ + PTR_W'(1);
  assign ptrDn     = (ptrQ == '0) ? PTR_MAX : ptrQ - PTR_W'(1);
  assign anyStrobe = strb.ldP | strb.incP | strb.decP | strb.testNe | strb.ldConst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ <= '0;
    end else if (strb.ldP) begin
      ptrQ <= strb.imm;
    end else if (strb.incP) begin
      ptrQ <= ptrUp;
    end else if (strb.decP || strb.ldConst) begin
      ptrQ <= ptrDn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= 1'b0;
    end else if (strb.testNe) begin
      flagQ <= (ptrQ != strb.imm);
    end
  end

  assign ldWrEn = strb.ldConst;

  for (genvar gi = 0; gi < NIBBLES; gi++) begin : g_wr
    logic hit;
    assign hit = strb.ldConst && (ptrQ == PTR_W'(gi));
    assign ldWrMask[gi] = hit;
    assign ldWrData[gi*NIB_W +: NIB_W] = hit ? strb.digit : '0;
  end

  // R3: pointer stays inside the register
  a_r3_ptr_range: assert property (@(posedge clk) disable iff (!rstN)
    ptrQ <= PTR_MAX);

  // R4: load takes the immediate
  a_r4_load: assert property (@(posedge clk) disable iff (!rstN)
    strb.ldP |=> (ptrQ == $past(strb.imm)));

  // R5: increment wraps from the top
  a_r5_inc_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (strb.incP && ptrQ == PTR_MAX) |=> (ptrQ == '0));

  // R6: decrement wraps from zero
  a_r6_dec_wrap: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.decP || strb.ldConst) && ptrQ == '0) |=> (ptrQ == PTR_MAX));

  // R7: flag holds without a test
  a_r7_flag_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.testNe |=> $stable(flagQ));

  // R8: load constant steps the pointer down by one
  a_r8_ldc_step: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ldConst && ptrQ != '0) |=> (ptrQ == $past(ptrQ) - PTR_W'(1)));

  // R8: write touches exactly one nibble
  a_r8_single_write: assert property (@(posedge clk) disable iff (!rstN)
    ldWrEn |-> ($countones(ldWrMask) == 1));

  // R10: no strobe leaves state alone
  a_r10_idle: assert property (@(posedge clk) disable iff (!rstN)
    !anyStrobe |=> ($stable(ptrQ) && $stable(flagQ)));

  // R10: at most one strobe per cycle
  a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.ldP, strb.incP, strb.decP, strb.testNe, strb.ldConst}));

endmodule

// File: rtl/nibble_field_sel.sv
module nibble_field_sel
  import nibsel_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               opValid,
  input  logic [2:0]         opCode,
  input  logic [2:0]         fieldSel,
  input  logic [PTR_W-1:0]   immVal,
  input  logic [NIB_W-1:0]   digitIn,
  output logic [NIBBLES-1:0] fieldMask,
  output logic [PTR_W-1:0]   ptrOut,
  output logic               testFlag,
  output logic               ldWrEn,
  output logic [NIBBLES-1:0] ldWrMask,
  output logic [WORD_W-1:0]  ldWrData
);

  ptrStrobe_t strb;

  nibsel_ctrl u_ctrl (
    .opValid (opValid),
    .opCode  (opCode),
    .immVal  (immVal),
    .digitIn (digitIn),
    .strb    (strb)
  );

  nibsel_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .ptrQ     (ptrOut),
    .flagQ    (testFlag),
    .ldWrEn   (ldWrEn),
    .ldWrMask (ldWrMask),
    .ldWrData (ldWrData)
  );

  nibsel_mask u_mask (
    .clk      (clk),
    .rstN     (rstN),
    .fieldSel (fieldSel),
    .ptr      (ptrOut),
    .maskO    (fieldMask)
  );

endmodule

// File: tb/tb_nibble_field_sel.sv
module tb_nibble_field_sel;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [2:0]  opCode = 3'd0;
  logic [2:0]  fieldSel = 3'd0;
  logic [3:0]  immVal = 4'd0;
  logic [3:0]  digitIn = 4'd0;
  logic [13:0] fieldMask;
  logic [3:0]  ptrOut;
  logic        testFlag;
  logic        ldWrEn;
  logic [13:0] ldWrMask;
  logic [55:0] ldWrData;

  nibble_field_sel dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .fieldSel(fieldSel), .immVal(immVal), .digitIn(digitIn),
    .fieldMask(fieldMask), .ptrOut(ptrOut), .testFlag(testFlag),
    .ldWrEn(ldWrEn), .ldWrMask(ldWrMask), .ldWrData(ldWrData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [3:0] ptr;
    logic       flag;
    string      req;
  } expItem_t;

  expItem_t scoreQ[$];
  int nChecks = 0;
  int nFails  = 0;
  int mP      = 0;
  logic mFlag = 1'b0;
  bit done    = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [13:0] expMask(input int fs, input int p);
    case (fs)
      0: return 14'(1) << p;
      1: return (14'(2) << p) - 14'(1);
      2: return 14'h0004;
      3: return 14'h0003;
      4: return 14'h2000;
      5: return 14'h1FF8;
      6: return 14'h3FF8;
      default: return 14'h3FFF;
    endcase
  endfunction

  task automatic doOp(input bit v, input int op, input int fs, input int imm,
                      input int dig, input string req);
    bit wr;
    expItem_t it;
    @(negedge clk);
    opValid  = v;
    opCode   = 3'(op);
    fieldSel = 3'(fs);
    immVal   = 4'(imm);
    digitIn  = 4'(dig);
    #1;
    chk(fieldMask == expMask(fs, mP), req, "fieldMask", 64'(fieldMask), 64'(expMask(fs, mP)));
    wr = v && (op == 5) && (dig <= 9);
    chk(ldWrEn == wr, req, "ldWrEn", 64'(ldWrEn), 64'(wr));
    if (wr) begin
      chk(ldWrMask == (14'(1) << mP), req, "ldWrMask", 64'(ldWrMask), 64'(14'(1) << mP));
      chk(ldWrData == (56'(dig) << (4*mP)), req, "ldWrData", 64'(ldWrData), 64'(56'(dig) << (4*mP)));
    end
    if (v) begin
      case (op)
        1: if (imm <= 13) mP = imm;
        2: mP = (mP == 13) ? 0 : mP + 1;
        3: mP = (mP == 0) ? 13 : mP - 1;
        4: mFlag = (mP != imm);
        5: if (dig <= 9) mP = (mP == 0) ? 13 : mP - 1;
        default: ;
      endcase
    end
    it.ptr  = 4'(mP);
    it.flag = mFlag;
    it.req  = req;
    scoreQ.push_back(it);
  endtask

  initial begin : monitor
    expItem_t it;
    forever begin
      @(posedge clk);
      #1;
      if (scoreQ.size() > 0) begin
        it = scoreQ.pop_front();
        chk(ptrOut == it.ptr, it.req, "ptrOut", 64'(ptrOut), 64'(it.ptr));
        chk(testFlag == it.flag, it.req, "testFlag", 64'(testFlag), 64'(it.flag));
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL R1 watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: reset state
    chk(ptrOut == 4'd0, "R1", "ptrOut", 64'(ptrOut), 64'd0);
    chk(testFlag == 1'b0, "R1", "testFlag", 64'(testFlag), 64'd0);
    chk(ldWrEn == 1'b0, "R1", "ldWrEn", 64'(ldWrEn), 64'd0);

    // R2: fixed fields at P=0
    for (int fs = 2; fs < 8; fs++) doOp(1, 0, fs, 0, 0, "R2");

    // R3 / R4: pointer and word-through-pointer masks
    doOp(1, 1, 0, 3, 0, "R4");
    doOp(1, 0, 1, 0, 0, "R3");
    doOp(1, 0, 0, 0, 0, "R3");
    doOp(1, 1, 1, 13, 0, "R4");
    doOp(1, 1, 1, 14, 0, "R4");
    doOp(1, 1, 1, 15, 0, "R4");
    doOp(1, 0, 1, 0, 0, "R3");

    // R5: increment wraps 13 -> 0
    doOp(1, 2, 0, 0, 0, "R5");
    doOp(1, 2, 0, 0, 0, "R5");
    doOp(1, 0, 1, 0, 0, "R5");

    // R6: decrement wraps 0 -> 13
    doOp(1, 1, 0, 0, 0, "R6");
    doOp(1, 3, 0, 0, 0, "R6");
    doOp(1, 3, 0, 0, 0, "R6");

    // R7: not-equal test
    doOp(1, 1, 0, 5, 0, "R7");
    doOp(1, 4, 0, 5, 0, "R7");
    doOp(1, 4, 0, 9, 0, "R7");
    doOp(1, 2, 0, 0, 0, "R7");
    doOp(1, 4, 0, 6, 0, "R7");
    doOp(1, 4, 0, 2, 0, "R7");

    // R8: load-constant run from the top through the wrap
    doOp(1, 1, 7, 13, 0, "R8");
    for (int k = 0; k < 16; k++) doOp(1, 5, 7, 0, k % 10, "R8");

    // R9: non-BCD digits ignored
    doOp(1, 5, 0, 0, 10, "R9");
    doOp(1, 5, 0, 0, 15, "R9");

    // R10: strobe low and unused opcodes
    doOp(0, 2, 0, 0, 0, "R10");
    doOp(0, 5, 0, 0, 3, "R10");
    doOp(0, 4, 0, 0, 0, "R10");
    doOp(1, 6, 0, 0, 0, "R10");
    doOp(1, 7, 0, 0, 0, "R10");
    doOp(1, 0, 0, 0, 0, "R10");

    // R2 / R3: sweep all fields at every pointer value
    for (int p = 0; p < 14; p++) begin
      doOp(1, 1, 0, p, 0, "R4");
      for (int fs = 0; fs < 8; fs++) doOp(1, 0, fs, 0, 0, (fs < 2) ? "R3" : "R2");
    end

    @(negedge clk);
    opValid = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule